// File: doc/BRIEF.md
# Complex-Gain Lookup Predistorter

This block sits ahead of a power amplifier and pre-corrects its amplitude compression and amplitude-dependent phase shift. Each clock it takes one I/Q baseband sample. It squares and sums the two components to get the signal level, and uses that level to select a complex gain from a 256-entry table. It multiplies the sample by that gain and streams the result out. Because each gain is complex, one multiply gives both the amplitude expansion and the opposing phase rotation. There is no decimation, so one sample enters and one sample leaves on every clock.

The table is loaded and updated through a write port that is driven by an outside adaptation routine. Entries that the routine never writes, such as those for levels above the peak of the drive signal, keep their previous contents. After reset every entry is 1.0+j0. With that table the block is transparent, which is the correct setting for the amplifier's linear range. A bypass input forces unity gain regardless of what the table holds.

Top module: `lut_predistorter`

## Requirements
- R1: While reset is asserted and afterwards until the first sample has crossed the pipeline, out_valid is 0 and out_i and out_q are 0. Reset sets every table entry to gain 1.0+j0 (real word 16384, imaginary word 0).
- R2: The table index is bits [31:24] of the unsigned 32-bit value in_i*in_i + in_q*in_q.
- R3: Gains are signed Q2.14, with 16384 meaning 1.0. The output is out_i = I*gi - Q*gq and out_q = I*gq + Q*gi, scaled down by 2^14.
- R4: Results are rounded by adding 2^13 before an arithmetic shift right by 14, so ties go toward positive infinity. They are then saturated to the range -32768..32767.
- R5: Latency is fixed at 4 clocks. out_valid is in_valid delayed by 4 clocks, and back-to-back samples are accepted on every clock.
- R6: When bypass is high with a sample, that sample leaves unchanged (out = in) whatever the table holds.
- R7: A write on the same clock edge as a sample is captured takes effect for that sample. A write to the same address on the following edge does not: the sample uses the old entry.
- R8: A write changes only the addressed entry. All other entries keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| bypass | input | 1 | Force unity gain for this sample |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table entry to write |
| wr_gi | input | 16 | Real part of gain, signed Q2.14 |
| wr_gq | input | 16 | Imaginary part of gain, signed Q2.14 |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Predistorted in-phase sample |
| out_q | output | 16 | Predistorted quadrature sample |

## Verification
Every result is due exactly four clock edges after its sample is captured. A table write is counted from the edge where it is presented: it affects a sample captured on that same edge, and is invisible to a sample captured one edge earlier. The bench's reference model keeps a four-deep chain of expected outputs that advances on every edge. It resolves each table lookup one edge after capture, before that edge's write is applied, and compares the end of the chain with the ports on every falling edge. Write collisions, rounding ties and saturation are driven deliberately so that their results land in known cycles.

// File: rtl/lut_predistorter.sv
module lut_predistorter #(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 bypass,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [GW-1:0] wr_gi,
  input  logic signed [GW-1:0] wr_gq,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int MW    = 2*DW;
  localparam int PW    = DW+GW;
  localparam int SW    = PW+2;
  localparam int DEPTH = 1 << AW;
  localparam logic signed [GW-1:0] UNITY = GW'(1) << FRAC;
  localparam logic signed [SW-1:0] HALF  = SW'(1) << (FRAC-1);
  localparam logic signed [SW-1:0] OMAX  = SW'((1 << (DW-1)) - 1);
  localparam logic signed [SW-1:0] OMIN  = -OMAX - SW'(1);

  logic signed [GW-1:0] tab_gi [DEPTH];
  logic signed [GW-1:0] tab_gq [DEPTH];

  logic signed [MW-1:0] sq_i, sq_q;
  logic        [MW-1:0] level;
  assign sq_i  = in_i * in_i;
  assign sq_q  = in_q * in_q;
  assign level = $unsigned(sq_i) + $unsigned(sq_q);

  logic                 v1, b1, v2, v3;
  logic [AW-1:0]        idx1;
  logic signed [DW-1:0] i1, q1, i2, q2;
  logic signed [GW-1:0] gi2, gq2;
  logic signed [SW-1:0] re3, im3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        tab_gi[k] <= UNITY;
        tab_gq[k] <= '0;
      end
    end else if (wr_en) begin
      tab_gi[wr_addr] <= wr_gi;
      tab_gq[wr_addr] <= wr_gq;
    end
  end

  logic signed [PW-1:0] p_ii, p_qq, p_iq, p_qi;
  assign p_ii = i2 * gi2;
  assign p_qq = q2 * gq2;
  assign p_iq = i2 * gq2;
  assign p_qi = q2 * gi2;

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] t;
    t = (x + HALF) >>> FRAC;
    if (t > OMAX)      return DW'(OMAX);
    else if (t < OMIN) return DW'(OMIN);
    else               return DW'(t);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, b1, v2, v3, out_valid} <= '0;
      idx1 <= '0;
      {i1, q1, i2, q2}   <= '0;
      {gi2, gq2}         <= '0;
      {re3, im3}         <= '0;
      {out_i, out_q}     <= '0;
    end else begin
      v1   <= in_valid;
      b1   <= bypass;
      i1   <= in_i;
      q1   <= in_q;
      idx1 <= level[MW-1 -: AW];
      v2   <= v1;
      i2   <= i1;
      q2   <= q1;
      gi2  <= b1 ? UNITY : tab_gi[idx1];
      gq2  <= b1 ? '0    : tab_gq[idx1];
      v3   <= v2;
      re3  <= SW'(p_ii) - SW'(p_qq);
      im3  <= SW'(p_iq) + SW'(p_qi);
      out_valid <= v3;
      out_i <= rnd_sat(re3);
      out_q <= rnd_sat(im3);
    end
  end

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 4) since_rst <= since_rst + 3'd1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 4) |-> (!out_valid && out_i == 0 && out_q == 0));

  a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 4) |-> (out_valid == $past(in_valid, 4)));

  a_r6_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 4 && $past(in_valid, 4) && $past(bypass, 4))
      |-> (out_i == $past(in_i, 4) && out_q == $past(in_q, 4)));

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en))
      |-> (tab_gi[$past(wr_addr)] == $past(wr_gi) && tab_gq[$past(wr_addr)] == $past(wr_gq)));

endmodule

// File: tb/lut_predistorter_tb_top.sv
`timescale 1ns/1ps
module lut_predistorter_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, bypass = 0, wr_en = 0;
  logic signed [15:0] in_i = 0, in_q = 0, wr_gi = 0, wr_gq = 0;
  logic [7:0] wr_addr = 0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #2.5 clk = ~clk;

  lut_predistorter dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .bypass(bypass), .wr_en(wr_en), .wr_addr(wr_addr), .wr_gi(wr_gi), .wr_gq(wr_gq),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  int tgi[256], tgq[256];
  bit av, bv, cv, dv;
  int ai, aq, bi, bq, ci, cq, di, dq;
  bit ab;

  function automatic int lvl_idx(int i, int q);
    longint m = longint'(i)*i + longint'(q)*q;
    return int'((m >> 24) & 255);
  endfunction

  function automatic int rsat(longint x);
    longint t = (x + 8192) >>> 14;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (tgi[k]) begin tgi[k] = 16384; tgq[k] = 0; end
      {av, bv, cv, dv, ab} = '0;
      {ai, aq, bi, bq, ci, cq, di, dq} = '0;
    end else begin
      int gi, gq, x;
      dv = cv; di = ci; dq = cq;
      cv = bv; ci = bi; cq = bq;
      x = lvl_idx(ai, aq);
      gi = ab ? 16384 : tgi[x];
      gq = ab ? 0 : tgq[x];
      bv = av;
      bi = rsat(longint'(ai)*gi - longint'(aq)*gq);
      bq = rsat(longint'(ai)*gq + longint'(aq)*gi);
      if (wr_en) begin tgi[wr_addr] = wr_gi; tgq[wr_addr] = wr_gq; end
      av = in_valid; ab = bypass; ai = in_i; aq = in_q;
    end
  end

  task automatic check_now();
    checks++;
    if (out_valid !== dv || (dv && (out_i !== 16'(di) || out_q !== 16'(dq)))) begin
      fails++;
      $display("FAIL %s: got v=%0b i=%0d q=%0d, expected v=%0b i=%0d q=%0d",
               req, out_valid, out_i, out_q, dv, di, dq);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    check_now();
  endtask

  task automatic idle_inputs();
    in_valid = 0; bypass = 0; wr_en = 0;
  endtask

  task automatic drain();
    idle_inputs();
    repeat (5) tick();
  endtask

  task automatic put(int i, int q);
    in_valid = 1; in_i = 16'(i); in_q = 16'(q);
  endtask

  task automatic wr(int a, int gi, int gq);
    wr_en = 1; wr_addr = 8'(a); wr_gi = 16'(gi); wr_gq = 16'(gq);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = "R1"; check_now();
    rst_n = 1;
    repeat (4) tick();

    req = "R3 default unity";
    for (int n = 0; n < 40; n++) begin put($urandom, $urandom); tick(); end
    drain();

    req = "R2 index select";
    idle_inputs();
    for (int a = 0; a < 256; a++) begin
      wr(a, 12000 + int'($urandom % 12000), int'($urandom % 8000) - 4000); tick();
    end
    wr_en = 0;
    for (int n = 0; n < 100; n++) begin put($urandom, $urandom); tick(); end
    for (int n = 0; n < 40; n++) begin put(int'($urandom % 4000), int'($urandom % 4000) - 2000); tick(); end
    drain();

    req = "R4 rounding tie";
    wr(4, 16385, 0); tick(); wr_en = 0;
    put(8192, 0); tick();
    put(-8192, 0); tick();
    drain();
    req = "R4 saturation";
    wr(107, 32767, 32767); tick(); wr_en = 0;
    put(30000, 30000); tick();
    put(-30000, -30000); tick();
    put(30000, -30000); tick();
    drain();

    req = "R6 bypass";
    for (int n = 0; n < 30; n++) begin put($urandom, $urandom); bypass = n[0]; tick(); end
    drain();

    req = "R5 valid gaps";
    for (int n = 0; n < 60; n++) begin
      put($urandom, $urandom); in_valid = ($urandom % 3) != 0; tick();
    end
    drain();

    req = "R7 write collision";
    begin
      int pi = 0, pq = 0;
      for (int n = 0; n < 60; n++) begin
        int ni = int'($signed(16'($urandom))), nq = int'($signed(16'($urandom)));
        put(ni, nq);
        if (n[0]) wr(lvl_idx(pi, pq), 9000 + n*100, -n*50);
        else      wr(lvl_idx(ni, nq), 20000 - n*100, n*50);
        tick();
        pi = ni; pq = nq;
      end
    end
    drain();

    req = "R8 single entry write";
    wr(5, 30000, -9000); tick(); wr_en = 0;
    for (int n = 0; n < 40; n++) begin put(int'($urandom % 20000), int'($urandom % 20000)); tick(); end
    put(9000, 0); tick();
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule